// File: doc/BRIEF.md
# Receive Character FIFO with Threshold-Driven DTR

This block buffers received characters for one serial channel and uses the buffer's fill level to pace the remote sender. A receiver pushes bytes in through a write strobe. A CPU-side read port pops them in arrival order, and the oldest byte is always shown on the read data output. The current fill level is an output.

An active-low DTR output is driven in one of two ways. In automatic mode, selected when the receiver is enabled and the DTR threshold is nonzero, the block asserts DTR (drives it low) while the FIFO holds fewer characters than the threshold. Once the level reaches the threshold, DTR is released high. It stays high until CPU reads bring the level back under the threshold. In any other case a manual register bit drives DTR directly.

A separate service-request threshold raises a request output once the level is high enough. A configuration flag reports threshold settings that cannot work. Writes into a full FIFO are lost and set a sticky overrun flag.

Top module: `rx_dtr_fifo`

## Requirements
- R1: After reset, level is 0, empty is 1, full is 0, dtr_n is 1 and overrun is 0.
- R2: Bytes are read out in the order they were accepted. While empty is 0, rd_data shows the oldest stored byte.
- R3: level counts the stored bytes (0 to 12) and updates one cycle after a strobe. A write is accepted when level < 12, a read is accepted when level > 0, and an accepted read and write in the same cycle leave level unchanged. full is 1 exactly when level is 12, and empty is 1 exactly when level is 0.
- R4: A write while full is dropped and does not change the level or the data. A read while empty has no effect.
- R5: A write while full sets overrun one cycle later. overrun stays set until a cycle with ovr_clr high clears it. When a full write and ovr_clr happen in the same cycle, overrun ends up set.
- R6: When rx_enable is 1 and dtr_thresh is nonzero at a clock edge, dtr_n after that edge is 1 if the new level is at or above dtr_thresh, and 0 otherwise. dtr_n changes in the same cycle as level. It is released when the threshold is reached and re-asserted only when reads bring the level below the threshold.
- R7: When rx_enable is 0 or dtr_thresh is 0 at a clock edge, dtr_n after that edge equals the inverse of man_dtr. Writing man_dtr = 1 asserts DTR (drives it low).
- R8: srq is 1, with no added delay, exactly when srq_thresh is nonzero and level >= srq_thresh.
- R9: cfg_err is 1, with no added delay, when dtr_thresh is nonzero and below srq_thresh, or when either threshold exceeds 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe from the receiver |
| wr_data | input | 8 | Received character |
| rd_en | input | 1 | CPU read strobe (pop) |
| rd_data | output | 8 | Oldest stored character |
| rx_enable | input | 1 | Receiver enabled |
| dtr_thresh | input | 4 | DTR fill threshold (0 means manual) |
| srq_thresh | input | 4 | Service-request fill threshold (0 means off) |
| man_dtr | input | 1 | Manual DTR bit (1 asserts DTR) |
| ovr_clr | input | 1 | Clears the overrun flag |
| level | output | 4 | Current fill level |
| empty | output | 1 | FIFO holds no byte |
| full | output | 1 | FIFO holds 12 bytes |
| dtr_n | output | 1 | Active-low DTR |
| srq | output | 1 | Service request |
| cfg_err | output | 1 | Invalid threshold configuration |
| overrun | output | 1 | Sticky write-while-full flag |

## Verification
The assertions check the following on every cycle:
- level never exceeds the depth, and the empty and full flags agree with level;
- a write while full sets overrun and leaves the level alone;
- dtr_n follows the fill level in automatic mode and the manual bit otherwise;
- srq and cfg_err agree with the thresholds.

Byte ordering, hysteresis over a full fill-and-drain sequence, the clear-versus-set collision on overrun, and mode changes in the middle of a stream can only be shown by the bench's scenarios. There, a queue-based model is compared against every output on every cycle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic {
        DTR_MANUAL = 1'b0,
        DTR_AUTO   = 1'b1
    } dtr_mode_e;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        mem_d = mem_q;
        if (push) begin
            mem_d[ptr_q.wp] = wr_data;
            ptr_d.wp = (ptr_q.wp == LAST) ? '0 : ptr_q.wp + 1'b1;
        end
        if (pop) begin
            ptr_d.rp = (ptr_q.rp == LAST) ? '0 : ptr_q.rp + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            ptr_q <= ptr_d;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[ptr_q.rp];
endmodule

// File: rtl/rxf_dtr_ctl.sv
module rxf_dtr_ctl #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_enable,
    input  logic [LVL_W-1:0] dtr_thresh,
    input  logic             man_dtr,
    input  logic [LVL_W-1:0] level_next,
    output logic             dtr_n
);
    import rxf_pkg::*;

    typedef struct packed {
        logic dtr_n;
    } dtr_st_t;

    dtr_mode_e mode;
    dtr_st_t   st_d, st_q;

    assign mode = (rx_enable && dtr_thresh != '0) ? DTR_AUTO : DTR_MANUAL;

    always_comb begin
        st_d = st_q;
        unique case (mode)
            DTR_AUTO:   st_d.dtr_n = (level_next >= dtr_thresh);
            DTR_MANUAL: st_d.dtr_n = ~man_dtr;
            default:    st_d.dtr_n = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{dtr_n: 1'b1};
        else        st_q <= st_d;
    end

    assign dtr_n = st_q.dtr_n;
endmodule

// File: rtl/rxf_cfg_check.sv
module rxf_cfg_check #(
    parameter int DEPTH = 12,
    parameter int LVL_W = 4
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] dtr_thresh,
    input  logic [LVL_W-1:0] srq_thresh,
    output logic             srq,
    output logic             cfg_err
);
    localparam logic [LVL_W-1:0] MAX_THR = LVL_W'(DEPTH);

    logic order_bad;
    logic range_bad;

    always_comb begin
        srq       = (srq_thresh != '0) && (level >= srq_thresh);
        order_bad = (dtr_thresh != '0) && (dtr_thresh < srq_thresh);
        range_bad = (dtr_thresh > MAX_THR) || (srq_thresh > MAX_THR);
        cfg_err   = order_bad || range_bad;
    end
endmodule

// File: rtl/rx_dtr_fifo.sv
module rx_dtr_fifo #(
    parameter int DEPTH  = 12,
    parameter int DATA_W = 8,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rx_enable,
    input  logic [LVL_W-1:0]  dtr_thresh,
    input  logic [LVL_W-1:0]  srq_thresh,
    input  logic              man_dtr,
    input  logic              ovr_clr,
    output logic [LVL_W-1:0]  level,
    output logic              empty,
    output logic              full,
    output logic              dtr_n,
    output logic              srq,
    output logic              cfg_err,
    output logic              overrun
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             overrun;
    } core_t;

    core_t core_d, core_q;
    logic  push, pop;

    always_comb begin
        push   = wr_en && (core_q.level != FULL_LVL);
        pop    = rd_en && (core_q.level != '0);
        core_d = core_q;
        case ({push, pop})
            2'b10:   core_d.level = core_q.level + 1'b1;
            2'b01:   core_d.level = core_q.level - 1'b1;
            default: core_d.level = core_q.level;
        endcase
        if (ovr_clr) core_d.overrun = 1'b0;
        if (wr_en && !push) core_d.overrun = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign level   = core_q.level;
    assign overrun = core_q.overrun;
    assign empty   = (core_q.level == '0);
    assign full    = (core_q.level == FULL_LVL);

    rxf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_store (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    rxf_dtr_ctl #(.LVL_W(LVL_W)) i_dtr (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable),
        .dtr_thresh(dtr_thresh), .man_dtr(man_dtr),
        .level_next(core_d.level), .dtr_n(dtr_n)
    );

    rxf_cfg_check #(.DEPTH(DEPTH), .LVL_W(LVL_W)) i_cfg (
        .level(core_q.level), .dtr_thresh(dtr_thresh), .srq_thresh(srq_thresh),
        .srq(srq), .cfg_err(cfg_err)
    );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int DEPTH = 12,
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             rx_enable,
    input logic [LVL_W-1:0] dtr_thresh,
    input logic [LVL_W-1:0] srq_thresh,
    input logic             man_dtr,
    input logic [LVL_W-1:0] level,
    input logic             empty,
    input logic             full,
    input logic             dtr_n,
    input logic             srq,
    input logic             cfg_err,
    input logic             overrun
);
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    a_r3_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (empty == (level == '0)) && (full == (level == LVL_W'(DEPTH))));

    a_r4_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (level == LVL_W'(DEPTH)));

    a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en) |=> overrun);

    a_r6_auto_dtr: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && dtr_thresh != '0) |=> (dtr_n == (level >= $past(dtr_thresh))));

    a_r7_manual_dtr: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enable || dtr_thresh == '0) |=> (dtr_n == !$past(man_dtr)));

    a_r8_srq: assert property (@(posedge clk) disable iff (!rst_n)
        srq == ((srq_thresh != '0) && (level >= srq_thresh)));

    a_r9_cfg_range: assert property (@(posedge clk) disable iff (!rst_n)
        (dtr_thresh > LVL_W'(DEPTH)) |-> cfg_err);
endmodule

bind rx_dtr_fifo rxf_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .rx_enable(rx_enable), .dtr_thresh(dtr_thresh), .srq_thresh(srq_thresh),
    .man_dtr(man_dtr), .level(level), .empty(empty), .full(full),
    .dtr_n(dtr_n), .srq(srq), .cfg_err(cfg_err), .overrun(overrun)
);

// File: tb/test_rx_dtr_fifo.sv
module test_rx_dtr_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       rx_enable = 1'b0, man_dtr = 1'b0, ovr_clr = 1'b0;
    logic [3:0] dtr_thresh = '0, srq_thresh = '0;
    logic [3:0] level;
    logic       empty, full, dtr_n, srq, cfg_err, overrun;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    byte unsigned q[$];
    bit m_ovr = 1'b0;
    bit m_dtr_n = 1'b1;

    always #5 clk = ~clk;

    rx_dtr_fifo i_rx_dtr_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rx_enable(rx_enable),
        .dtr_thresh(dtr_thresh), .srq_thresh(srq_thresh), .man_dtr(man_dtr),
        .ovr_clr(ovr_clr), .level(level), .empty(empty), .full(full),
        .dtr_n(dtr_n), .srq(srq), .cfg_err(cfg_err), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int sz = q.size();
        bit e_srq = (srq_thresh != 0) && (sz >= srq_thresh);
        bit e_cfg = ((dtr_thresh != 0) && (dtr_thresh < srq_thresh)) ||
                    (dtr_thresh > 12) || (srq_thresh > 12);
        chk(level == sz, "R3 level", level, sz);
        chk(empty == (sz == 0), "R3 empty", empty, sz == 0);
        chk(full == (sz == 12), "R3 full", full, sz == 12);
        if (sz > 0) chk(rd_data == q[0], "R2 rd_data", rd_data, q[0]);
        chk(overrun == m_ovr, "R5 overrun", overrun, m_ovr);
        chk(dtr_n == m_dtr_n, "R6/R7 dtr_n", dtr_n, m_dtr_n);
        chk(srq == e_srq, "R8 srq", srq, e_srq);
        chk(cfg_err == e_cfg, "R9 cfg_err", cfg_err, e_cfg);
    endtask

    task automatic step(input bit w, input byte unsigned d, input bit r, input bit clr);
        int old;
        wr_en = w; wr_data = d; rd_en = r; ovr_clr = clr;
        @(posedge clk);
        old = q.size();
        if (r && old > 0) void'(q.pop_front());
        if (w && old < 12) q.push_back(d);
        m_ovr = (m_ovr && !clr) || (w && old == 12);
        if (rx_enable && dtr_thresh != 0) m_dtr_n = (q.size() >= dtr_thresh);
        else                              m_dtr_n = !man_dtr;
        @(negedge clk);
        compare_all();
        wr_en = 0; rd_en = 0; ovr_clr = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(level == 0 && empty && !full, "R1 level/flags", level, 0);
        chk(dtr_n == 1'b1, "R1 dtr_n", dtr_n, 1);
        chk(overrun == 1'b0, "R1 overrun", overrun, 0);

        // R6 auto mode, threshold 8, service at 4: fill past full
        rx_enable = 1; dtr_thresh = 8; srq_thresh = 4;
        for (int i = 0; i < 14; i++) step(1, 8'(8'h30 + i), 0, 0);
        // R4 R5 writes above were partly dropped; clear overrun
        step(0, 0, 0, 1);
        // R5 collision: full write with clear, set wins
        step(1, 8'hEE, 0, 1);
        step(0, 0, 0, 1);
        // R6 hysteresis while draining, R2 ordering
        for (int i = 0; i < 13; i++) step(0, 0, 1, 0);
        // R4 read while empty
        step(0, 0, 1, 0);
        // R3 simultaneous read/write
        for (int i = 0; i < 9; i++) step(1, 8'(8'h50 + i), 0, 0);
        for (int i = 0; i < 6; i++) step(1, 8'(8'h70 + i), 1, 0);
        // R7 manual modes
        dtr_thresh = 0;
        step(0, 0, 0, 0);
        man_dtr = 1; step(0, 0, 0, 0);
        man_dtr = 0; step(0, 0, 0, 0);
        dtr_thresh = 5; rx_enable = 0; man_dtr = 1;
        step(1, 8'h11, 0, 0);
        rx_enable = 1; step(0, 0, 0, 0);
        // R9 config errors
        dtr_thresh = 3; srq_thresh = 5; step(0, 0, 0, 0);
        dtr_thresh = 13; srq_thresh = 2; step(0, 0, 0, 0);
        dtr_thresh = 10; srq_thresh = 14; step(0, 0, 0, 0);
        dtr_thresh = 0; srq_thresh = 0; step(0, 0, 0, 0);
        // mixed pseudo-random stream
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i % 50 == 0) begin
                dtr_thresh = 4'(lfsr[3:0] % 14);
                srq_thresh = 4'(lfsr[7:4] % 13);
                rx_enable = lfsr[8];
                man_dtr = lfsr[9];
            end
            step(lfsr[0] | lfsr[5], lfsr[15:8], lfsr[1] & lfsr[6], lfsr[2] & lfsr[3] & lfsr[4]);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule